// File: doc/BRIEF.md
# Frame-Synchronised Timer Tick Backlog Counter

This block produces a periodic timer tick derived from the video timing chain and keeps a small backlog of ticks that the processor has not yet serviced. A scan-line strobe advances a line counter; the tick fires once a set number of lines into each frame flyback and then every `LINE_PERIOD` lines until the next flyback begins. With the default 64 µs line, 52 lines give a 3.328 ms timer period at both frame rates.

Each tick adds one to a saturating 4-bit backlog. While the backlog is non-zero a level interrupt request is held towards the CPU. Software that could not respond in time reads the counter port to learn how many ticks it missed; the read returns the backlog and clears it, so interrupt handling and catch-up share one mechanism.

Top module: `frame_tick_counter`

## Requirements
- R1: While reset is asserted and after its release, the backlog is 0 and the interrupt request is low.
- R2: With no flyback onset seen since reset, the first tick follows the 52nd line strobe after reset, and further ticks follow every 52 line strobes.
- R3: A flyback onset (first cycle with `flybackActive` high after a low cycle) restarts the cadence: a tick follows the 2nd line strobe after the onset, then one every 52 line strobes.
- R4: A line strobe in the same cycle as a flyback onset is not counted towards the cadence.
- R5: Each tick raises the backlog by exactly one; a line strobe sampled at clock edge N that completes an interval makes the new backlog visible after clock edge N+1.
- R6: The backlog saturates at 15 and never wraps to 0 on further ticks.
- R7: `irqReq` is high exactly when the backlog is non-zero.
- R8: `readData[3:0]` always shows the current backlog, including in the cycle `readStrobe` is high, and `readData[7:4]` is always 0.
- R9: A clock edge that samples `readStrobe` high leaves the backlog at 0.
- R10: A tick that would increment the backlog on the same edge as a clearing read is lost: the backlog is 0 after that edge.
- R11: Holding `flybackActive` high for many lines does not restart the cadence again; only the onset does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStrobe | input | 1 | One-cycle pulse per scan line from video timing |
| flybackActive | input | 1 | High during vertical flyback |
| readStrobe | input | 1 | One-cycle CPU read of the counter port |
| irqReq | output | 1 | Level interrupt request, high while backlog is non-zero |
| readData | output | 8 | Counter port data: backlog on bits 3..0, zeros above |

## Verification
On every cycle the assertions hold the interrupt to the backlog, keep the upper data bits at zero, confirm that a read empties the counter, that the backlog never steps by more than one, never leaves 15 except by a read, and only rises two edges after a line strobe. Whether ticks land on the right line (52 after reset, 2 after flyback onset, no retrigger during a long flyback, the strobe coinciding with onset ignored) and that a tick colliding with a read is dropped can only be shown by the bench's scenarios against its line-counting reference model.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  // Strobes passed from the cadence control to the backlog datapath.
  typedef struct packed {
    logic tick;   // one interval completed
    logic clear;  // CPU read of the counter port
  } ctrlStrobe_t;

endpackage

// File: rtl/ftc_cadence_ctrl.sv
module ftc_cadence_ctrl
  import ftc_pkg::*;
#(
  parameter int LINE_PERIOD = 52,
  parameter int FLY_OFFSET  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStrobe,
  input  logic        flybackActive,
  input  logic        readStrobe,
  output ctrlStrobe_t ctrl
);

  localparam int LINE_W = (LINE_PERIOD > 1) ? $clog2(LINE_PERIOD) : 1;
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINE_PERIOD - 1);
  localparam logic [LINE_W-1:0] LINE_LOAD = LINE_W'(LINE_PERIOD - FLY_OFFSET);

  logic [LINE_W-1:0] lineCnt;
  logic              flyPrev;
  logic              flyOnset;
  logic              atLast;
  logic              tickQ;

  assign flyOnset = flybackActive && !flyPrev;
  assign atLast   = (lineCnt == LINE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flyPrev <= 1'b0;
    end else begin
      flyPrev <= flybackActive;
    end
  end

  // Line counter: onset reloads so the tick lands FLY_OFFSET lines later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (flyOnset) begin
      lineCnt <= LINE_LOAD;
    end else if (lineStrobe) begin
      lineCnt <= atLast ? '0 : lineCnt + LINE_W'(1);
    end
  end

  // Single-cycle tick from the terminal-count edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= 1'b0;
    end else begin
      tickQ <= lineStrobe && atLast && !flyOnset;
    end
  end

  always_comb begin
    ctrl.tick  = tickQ;
    ctrl.clear = readStrobe;
  end

endmodule

// File: rtl/ftc_backlog_path.sv
module ftc_backlog_path
  import ftc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  output logic              irqReq,
  output logic [DATA_W-1:0] readData
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] backlog;

  // Clear wins over a coincident tick: that tick is dropped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      backlog <= '0;
    end else if (ctrl.clear) begin
      backlog <= '0;
    end else if (ctrl.tick && (backlog != CNT_MAX)) begin
      backlog <= backlog + CNT_W'(1);
    end
  end

  assign irqReq   = |backlog;
  assign readData = DATA_W'(backlog);

endmodule

// File: rtl/frame_tick_counter.sv
module frame_tick_counter
  import ftc_pkg::*;
#(
  parameter int LINE_PERIOD = 52,
  parameter int FLY_OFFSET  = 2,
  parameter int CNT_W       = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              flybackActive,
  input  logic              readStrobe,
  output logic              irqReq,
  output logic [DATA_W-1:0] readData
);

  ctrlStrobe_t ctrl;

  ftc_cadence_ctrl #(
    .LINE_PERIOD (LINE_PERIOD),
    .FLY_OFFSET  (FLY_OFFSET)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .lineStrobe    (lineStrobe),
    .flybackActive (flybackActive),
    .readStrobe    (readStrobe),
    .ctrl          (ctrl)
  );

  ftc_backlog_path #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .irqReq   (irqReq),
    .readData (readData)
  );

endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStrobe,
  input logic              readStrobe,
  input logic              irqReq,
  input logic [DATA_W-1:0] readData
);

  logic [CNT_W-1:0] cnt;
  assign cnt = readData[CNT_W-1:0];

  a_r7_irq_tracks_count: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (cnt != '0));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    readData[DATA_W-1:CNT_W] == '0);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> (cnt == '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt == '1) && !readStrobe) |=> (cnt == '1));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))));

  a_r5_rise_after_line: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(readStrobe) && (cnt != $past(cnt))) |-> $past(lineStrobe, 2));

endmodule

bind frame_tick_counter ftc_checker #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .lineStrobe (lineStrobe),
  .readStrobe (readStrobe),
  .irqReq     (irqReq),
  .readData   (readData)
);

// File: tb/frame_tick_counter_tb_top.sv
module frame_tick_counter_tb_top;

  localparam int PERIOD = 52;
  localparam int OFFSET = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStrobe = 1'b0;
  logic       flybackActive = 1'b0;
  logic       readStrobe = 1'b0;
  logic       irqReq;
  logic [7:0] readData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference model
  int mCount = 0;
  int mLinesLeft = PERIOD;
  bit mPend = 1'b0;
  bit mFlyPrev = 1'b0;

  frame_tick_counter dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .lineStrobe    (lineStrobe),
    .flybackActive (flybackActive),
    .readStrobe    (readStrobe),
    .irqReq        (irqReq),
    .readData      (readData)
  );

  always #4 clk = ~clk;

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mLinesLeft = PERIOD; mPend = 1'b0; mFlyPrev = 1'b0;
    end else begin
      if (readStrobe) mCount = 0;
      else if (mPend && mCount < 15) mCount++;
      if (flybackActive && !mFlyPrev) begin
        mLinesLeft = OFFSET; mPend = 1'b0;
      end else if (lineStrobe) begin
        mLinesLeft--;
        if (mLinesLeft == 0) begin mPend = 1'b1; mLinesLeft = PERIOD; end
        else mPend = 1'b0;
      end else begin
        mPend = 1'b0;
      end
      mFlyPrev = flybackActive;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R7 per-cycle irq", int'(irqReq), int'(mCount != 0));
      check("R8 per-cycle data", int'(readData), mCount);
    end
  end

  task automatic pulseLine();
    @(negedge clk) lineStrobe = 1'b1;
    @(negedge clk) lineStrobe = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic readBacklog(output int v);
    @(negedge clk) readStrobe = 1'b1;
    v = int'(readData);
    @(negedge clk) readStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check("R1 reset data", int'(readData), 0);
    check("R1 reset irq", int'(irqReq), 0);
    @(negedge clk) rstN = 1'b1;
    settle();
    check("R1 after release", int'(readData), 0);

    // R2: cadence from reset
    for (int i = 0; i < PERIOD - 1; i++) pulseLine();
    settle(); settle();
    check("R2 before 52nd line", int'(readData), 0);
    pulseLine();
    check("R5 not yet visible", int'(readData), 0);
    settle();
    check("R2 tick at 52nd line", int'(readData), 1);
    check("R7 irq raised", int'(irqReq), 1);

    readBacklog(v);
    check("R8 read value", v, 1);
    check("R9 cleared", int'(readData), 0);
    check("R7 irq dropped", int'(irqReq), 0);

    // R3 / R11: flyback restart, long flyback
    @(negedge clk) flybackActive = 1'b1;
    pulseLine(); settle(); settle();
    check("R3 after 1 line", int'(readData), 0);
    pulseLine(); settle();
    check("R3 flyback tick", int'(readData), 1);
    for (int i = 0; i < PERIOD - 1; i++) begin
      if (i == 22) flybackActive = 1'b0;
      pulseLine();
    end
    settle();
    check("R11 no retrigger", int'(readData), 1);
    pulseLine(); settle();
    check("R3 52 lines after flyback tick", int'(readData), 2);
    readBacklog(v);
    check("R8 read two", v, 2);

    // R4: strobe coinciding with onset ignored
    settle();
    @(negedge clk) begin flybackActive = 1'b1; lineStrobe = 1'b1; end
    @(negedge clk) lineStrobe = 1'b0;
    pulseLine(); settle(); settle();
    check("R4 coincident strobe ignored", int'(readData), 0);
    pulseLine(); settle();
    check("R4 tick on 2nd later line", int'(readData), 1);
    readBacklog(v);

    // R5 / R6: step and saturate
    for (int k = 0; k < 17; k++) begin
      @(negedge clk) flybackActive = 1'b0;
      @(negedge clk) flybackActive = 1'b1;
      pulseLine(); pulseLine(); settle();
      if (k < 15) check("R5 step by one", int'(readData), k + 1);
      else check("R6 saturated", int'(readData), 15);
    end
    check("R7 irq at 15", int'(irqReq), 1);
    readBacklog(v);
    check("R8 read 15", v, 15);
    check("R9 cleared from 15", int'(readData), 0);
    check("R8 upper bits", int'(readData[7:4]), 0);

    // R10: tick colliding with read
    @(negedge clk) flybackActive = 1'b0;
    @(negedge clk) flybackActive = 1'b1;
    pulseLine();
    @(negedge clk) lineStrobe = 1'b1;
    @(negedge clk) begin lineStrobe = 1'b0; readStrobe = 1'b1; end
    @(negedge clk) readStrobe = 1'b0;
    settle(); settle();
    check("R10 tick lost", int'(readData), 0);
    check("R10 irq low", int'(irqReq), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule